// File: doc/BRIEF.md
# Option-Select Configuration Register File and Dual-Channel I/O Decoder

This block sits on a two-channel serial adapter for a bus that sets up its cards through option-select registers instead of jumpers. It holds a fixed 16-bit adapter identifier and a small set of writable registers. These registers enable the card and pick, for each channel, one of sixteen I/O base addresses and a 2-bit interrupt-level code.

Each bus I/O cycle presents a 16-bit address and a strobe. The block compares the upper 13 address bits against the base of each channel. It raises at most one chip select, and it passes the low three bits through as the register offset into the selected channel's UART. The software-side port is a simple synchronous byte interface. A read request returns data one clock later.

Register map (3-bit address):

- 0: identifier low byte, read-only.
- 1: identifier high byte, read-only.
- 2: control. Bit 0 is card enable.
- 3: channel 0 selection.
- 4: channel 1 selection.

A selection byte has these fields:

- bits [2:0]: table index.
- bit 3: high-half flag, which adds 8000H.
- bits [5:4]: interrupt code.

Top module: `optsel_decoder`

## Requirements
- R1: After a synchronous active-low reset the control, both selection registers and the read data are zero. The card is disabled, so no chip select is raised.
- R2: Reading address 0 returns 3CH and reading address 1 returns 5AH (default identifier 5A3CH). Writes to these two addresses change nothing.
- R3: Address 2 stores bit 0 (card enable) and reads back with bits [7:1] zero. Addresses 3 and 4 store bits [5:0] and read back with bits [7:6] zero.
- R4: A channel's base is STD_BASES[sel[2:0]], plus 8000H when sel[3] is 1. The default table for indices 0..7 is 03F8H, 02F8H, 3220H, 3228H, 4220H, 4228H, 5220H, 5228H.
- R5: chan_cs[n] is raised only when io_strobe is 1, the card is enabled and io_addr[15:3] equals base[15:3]. All 16 address bits take part, so an address that differs from the base only in bit 15 does not select.
- R6: reg_off always equals io_addr[2:0].
- R7: The two channels decode independently. Each hits only its own 8-address window.
- R8: When both channels resolve to the same base, only chan_cs[0] is raised. chan_cs never has more than one bit set.
- R9: irq_lvl[2n+1:2n] equals bits [5:4] of channel n's selection register.
- R10: cfg_rdata is updated on the clock edge at which cfg_rd is 1 and holds otherwise. Addresses 5 to 7 read as zero, and writes to them change no register.
- R11: With card enable 0 no chip select is raised for any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rd | input | 1 | Configuration read request |
| cfg_rdata | output | 8 | Registered read data |
| io_addr | input | 16 | Bus I/O address |
| io_strobe | input | 1 | I/O cycle active |
| chan_cs | output | 2 | Per-channel chip select, channel 0 in bit 0 |
| reg_off | output | 3 | Register offset within the UART |
| irq_lvl | output | 4 | Interrupt code per channel, channel n in bits [2n+1:2n] |

## Verification
The bench targets addresses one step outside each window, at the base minus one and the base plus eight. A decoder that compared too few bits, or used the wrong boundary, would select there.

It also probes the base with bit 15 flipped. A design that dropped the 8000H offset or ignored the top bit would answer both halves.

Other directed cases cover these faults:

- Both channels on one base: a missing priority would raise two selects.
- Writes to the identifier and unused addresses: a design that accepted them would change later reads or decoding.
- Decoding while the card is disabled or the strobe is low: a design that skipped these gates would raise a select.

// File: rtl/optsel_pkg.sv
// Package: shared constants and the per-channel selection record for the
// option-select decoder. Assumes a 3-bit configuration address space.
package optsel_pkg;
    localparam int CFG_AW       = 3;
    localparam int IO_AW        = 16;
    localparam int WIN_BITS     = 3;
    localparam int REG_ID_LO    = 0;
    localparam int REG_ID_HI    = 1;
    localparam int REG_CTRL     = 2;
    localparam int REG_CH_FIRST = 3;

    // Channel selection byte, bits [5:0].
    typedef struct packed {
        logic [1:0] irq;
        logic       hi;
        logic [2:0] idx;
    } chan_cfg_t;
endpackage

// File: rtl/optsel_regfile.sv
// Option-select register file: two read-only identifier bytes, a control
// register holding card enable, and one selection register per channel.
// Assumes REG_CH_FIRST + NUM_CH fits in the 3-bit address space.
module optsel_regfile
    import optsel_pkg::*;
#(
    parameter int          NUM_CH     = 2,
    parameter logic [15:0] ADAPTER_ID = 16'h5A3C
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic                 cfg_wr,
    input  logic [7:0]           cfg_wdata,
    input  logic                 cfg_rd,
    output logic [7:0]           cfg_rdata,
    output logic                 card_en,
    output chan_cfg_t [NUM_CH-1:0] chan_cfg
);
    localparam int CFG_W = $bits(chan_cfg_t);

    logic [7:0] rd_next;

    // Capture writes to the control and channel selection registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            card_en  <= 1'b0;
            chan_cfg <= '0;
        end else if (cfg_wr) begin
            if (cfg_addr == CFG_AW'(REG_CTRL))
                card_en <= cfg_wdata[0];
            for (int ch = 0; ch < NUM_CH; ch++)
                if (cfg_addr == CFG_AW'(REG_CH_FIRST + ch))
                    chan_cfg[ch] <= chan_cfg_t'(cfg_wdata[CFG_W-1:0]);
        end
    end

    // Select the byte addressed by cfg_addr; unmapped addresses give zero.
    always_comb begin
        rd_next = '0;
        if (cfg_addr == CFG_AW'(REG_ID_LO))
            rd_next = ADAPTER_ID[7:0];
        if (cfg_addr == CFG_AW'(REG_ID_HI))
            rd_next = ADAPTER_ID[15:8];
        if (cfg_addr == CFG_AW'(REG_CTRL))
            rd_next = {7'b0, card_en};
        for (int ch = 0; ch < NUM_CH; ch++)
            if (cfg_addr == CFG_AW'(REG_CH_FIRST + ch))
                rd_next = {{(8-CFG_W){1'b0}}, chan_cfg[ch]};
    end

    // Register the read data on a read request, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_rdata <= '0;
        else if (cfg_rd)
            cfg_rdata <= rd_next;
    end

    // R2: the identifier byte is returned whatever was written before
    assert_id_lo_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_addr == CFG_AW'(REG_ID_LO)) |=> (cfg_rdata == ADAPTER_ID[7:0]));

    // R3: card enable follows the written bit 0
    assert_ctrl_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == CFG_AW'(REG_CTRL)) |=> (card_en == $past(cfg_wdata[0])));

    // R10: unmapped addresses read as zero
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_addr >= CFG_AW'(REG_CH_FIRST + NUM_CH)) |=> (cfg_rdata == 8'h00));

    // R10: read data holds without a read request
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rd && $past(rst_n)) |=> $stable(cfg_rdata));
endmodule

// File: rtl/optsel_chan_match.sv
// One channel's window match. It forms the base from the standard-base
// table and the high-half flag, then compares the window bits of the I/O
// address. Assumes table entries lie below 8000H.
module optsel_chan_match
    import optsel_pkg::*;
#(
    parameter logic [7:0][15:0] STD_BASES = '0
) (
    input  chan_cfg_t        cfg,
    input  logic [IO_AW-1:0] io_addr,
    output logic             hit
);
    logic [IO_AW-1:0] base;

    // Build the base and compare everything above the 8-byte window.
    always_comb begin
        base = STD_BASES[cfg.idx] + (cfg.hi ? 16'h8000 : 16'h0000);
        hit  = (io_addr[IO_AW-1:WIN_BITS] == base[IO_AW-1:WIN_BITS]);
    end
endmodule

// File: rtl/optsel_decoder.sv
// Top level: option-select register file plus the per-channel address
// decoder with a fixed priority (lowest channel wins). Chip selects and
// offset are combinational from io_addr/io_strobe; configuration reads take
// one clock.
module optsel_decoder
    import optsel_pkg::*;
#(
    parameter int               NUM_CH     = 2,
    parameter logic [15:0]      ADAPTER_ID = 16'h5A3C,
    parameter logic [7:0][15:0] STD_BASES  = {16'h5228, 16'h5220, 16'h4228, 16'h4220,
                                              16'h3228, 16'h3220, 16'h02F8, 16'h03F8}
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CFG_AW-1:0]     cfg_addr,
    input  logic                  cfg_wr,
    input  logic [7:0]            cfg_wdata,
    input  logic                  cfg_rd,
    output logic [7:0]            cfg_rdata,
    input  logic [IO_AW-1:0]      io_addr,
    input  logic                  io_strobe,
    output logic [NUM_CH-1:0]     chan_cs,
    output logic [WIN_BITS-1:0]   reg_off,
    output logic [2*NUM_CH-1:0]   irq_lvl
);
    logic                  card_en;
    chan_cfg_t [NUM_CH-1:0] chan_cfg;
    logic [NUM_CH-1:0]     hit;

    optsel_regfile #(.NUM_CH(NUM_CH), .ADAPTER_ID(ADAPTER_ID)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_addr (cfg_addr),
        .cfg_wr   (cfg_wr),
        .cfg_wdata(cfg_wdata),
        .cfg_rd   (cfg_rd),
        .cfg_rdata(cfg_rdata),
        .card_en  (card_en),
        .chan_cfg (chan_cfg)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        optsel_chan_match #(.STD_BASES(STD_BASES)) u_match (
            .cfg    (chan_cfg[ch]),
            .io_addr(io_addr),
            .hit    (hit[ch])
        );
        assign irq_lvl[2*ch +: 2] = chan_cfg[ch].irq;
    end

    assign reg_off = io_addr[WIN_BITS-1:0];

    // Gate the hits and let the lowest-numbered hitting channel win.
    always_comb begin
        logic taken;
        taken   = 1'b0;
        chan_cs = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            chan_cs[ch] = io_strobe && card_en && hit[ch] && !taken;
            taken       = taken || hit[ch];
        end
    end

    // R8: never more than one chip select
    assert_cs_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_cs));

    // R11: a disabled card selects nothing
    assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !card_en |-> (chan_cs == '0));

    // R5: no select outside an I/O cycle
    assert_no_strobe_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !io_strobe |-> (chan_cs == '0));

    // R8: channel 0 wins a shared base
    assert_ch0_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_strobe && card_en && hit[0]) |-> (chan_cs == NUM_CH'(1)));
endmodule

// File: tb/optsel_decoder_bench.sv
// Bench: directed corner cases plus seeded random configurations and
// addresses, checked against a reference model computed here.
module optsel_decoder_bench;
    localparam logic [15:0] ID = 16'h5A3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        cfg_rd = 1'b0;
    logic [7:0]  cfg_rdata;
    logic [15:0] io_addr = '0;
    logic        io_strobe = 1'b0;
    logic [1:0]  chan_cs;
    logic [2:0]  reg_off;
    logic [3:0]  irq_lvl;

    int n_tests = 0;
    int n_fail = 0;
    int seed_dummy;

    logic       m_en;
    logic [5:0] m_sel [2];

    always #5 clk = ~clk;

    optsel_decoder u_optsel_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata),
        .io_addr(io_addr), .io_strobe(io_strobe), .chan_cs(chan_cs),
        .reg_off(reg_off), .irq_lvl(irq_lvl)
    );

    function automatic logic [15:0] std_base(input logic [2:0] i);
        case (i)
            3'd0: return 16'h03F8;
            3'd1: return 16'h02F8;
            3'd2: return 16'h3220;
            3'd3: return 16'h3228;
            3'd4: return 16'h4220;
            3'd5: return 16'h4228;
            3'd6: return 16'h5220;
            default: return 16'h5228;
        endcase
    endfunction

    function automatic logic [15:0] exp_base(input logic [5:0] s);
        return std_base(s[2:0]) | (s[3] ? 16'h8000 : 16'h0000);
    endfunction

    function automatic logic [1:0] exp_cs(input logic [15:0] a, input logic stb);
        logic h0, h1;
        h0 = (a[15:3] == exp_base(m_sel[0])[15:3]);
        h1 = (a[15:3] == exp_base(m_sel[1])[15:3]);
        if (!stb || !m_en) return 2'b00;
        if (h0) return 2'b01;
        if (h1) return 2'b10;
        return 2'b00;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (a == 3'd2) m_en = d[0];
        if (a == 3'd3) m_sel[0] = d[5:0];
        if (a == 3'd4) m_sel[1] = d[5:0];
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk);
        cfg_addr = a; cfg_rd = 1'b1;
        @(negedge clk);
        cfg_rd = 1'b0;
        check(req, {24'b0, cfg_rdata}, {24'b0, exp});
    endtask

    task automatic io_check(input string req, input logic [15:0] a, input logic stb);
        @(negedge clk);
        io_addr = a; io_strobe = stb;
        #1;
        check(req, {30'b0, chan_cs}, {30'b0, exp_cs(a, stb)});
        check("R6", {29'b0, reg_off}, {29'b0, a[2:0]});
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] hold;
        seed_dummy = $urandom(32'd1234);
        m_en = 1'b0; m_sel[0] = '0; m_sel[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd_check("R1", 3'd2, 8'h00);
        rd_check("R1", 3'd3, 8'h00);
        rd_check("R1", 3'd4, 8'h00);
        io_check("R1", 16'h03F8, 1'b1);
        // R2: identifier, writes ignored
        wr(3'd0, 8'hFF); wr(3'd1, 8'h00);
        rd_check("R2", 3'd0, 8'h3C);
        rd_check("R2", 3'd1, 8'h5A);
        // R3: readback masks
        wr(3'd2, 8'hFF);
        rd_check("R3", 3'd2, 8'h01);
        wr(3'd3, 8'hFF);
        rd_check("R3", 3'd3, 8'h3F);
        check("R9", {28'b0, irq_lvl}, 32'h3);
        // R10: unused addresses and read hold
        wr(3'd5, 8'hAA); wr(3'd6, 8'h55); wr(3'd7, 8'hFF);
        rd_check("R10", 3'd5, 8'h00);
        rd_check("R10", 3'd7, 8'h00);
        rd_check("R10", 3'd3, 8'h3F);
        hold = cfg_rdata;
        @(negedge clk); cfg_addr = 3'd0;
        @(negedge clk);
        check("R10", {24'b0, cfg_rdata}, {24'b0, hold});
        // R4, R5: window edges and bit 15
        wr(3'd3, 8'h00); wr(3'd4, 8'h09);
        io_check("R4", 16'h03F8, 1'b1);
        io_check("R5", 16'h03F7, 1'b1);
        io_check("R5", 16'h0400, 1'b1);
        io_check("R5", 16'h83F8, 1'b1);
        io_check("R4", 16'h82FF, 1'b1);
        io_check("R5", 16'h02F8, 1'b1);
        io_check("R5", 16'h03FC, 1'b0);
        // R7: independent windows
        wr(3'd4, 8'h07);
        io_check("R7", 16'h5228, 1'b1);
        io_check("R7", 16'h03FF, 1'b1);
        // R8: shared base
        wr(3'd4, 8'h30);
        io_check("R8", 16'h03FA, 1'b1);
        check("R9", {28'b0, irq_lvl}, 32'h0C);
        // R11: disabled card
        wr(3'd2, 8'h00);
        io_check("R11", 16'h03F8, 1'b1);
        wr(3'd2, 8'h01);
        // random configurations
        for (int k = 0; k < 60; k++) begin
            wr(3'd2, 8'($urandom_range(0, 3)));
            wr(3'd3, 8'($urandom));
            wr(3'd4, 8'($urandom));
            check("R9", {28'b0, irq_lvl}, {28'b0, m_sel[1][5:4], m_sel[0][5:4]});
            rd_check("R3", 3'd4, {2'b0, m_sel[1]});
            for (int j = 0; j < 20; j++) begin
                logic [15:0] a;
                int pick;
                pick = $urandom_range(0, 3);
                a = $urandom;
                if (pick == 0) a = exp_base(m_sel[0]) + 16'($urandom_range(0, 7));
                if (pick == 1) a = exp_base(m_sel[1]) + 16'($urandom_range(0, 7));
                if (pick == 2) a = exp_base(m_sel[$urandom_range(0, 1)]) ^ 16'h8000;
                io_check("R5", a, ($urandom_range(0, 7) != 0));
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule